// File: doc/BRIEF.md
# Register-Reference Accumulator Executor

This block carries out the register-reference class of a 16-bit accumulator machine. The surrounding core hands it the fetched instruction word together with an execute strobe and the current accumulator, extend bit and program counter. The block decodes the word and produces the next accumulator, extend bit and program counter one clock later. It also keeps a halt flag and flags malformed words. The program counter input is taken to already point past the instruction, so a skip adds one more step.

An instruction belongs to the class when its top four bits read 4'h7, meaning the mode bit is 0 and the opcode is 111. Exactly one of the low twelve bits then names the operation. The operations are clears and complements of the accumulator and extend bit, an increment, two rotations through the extend bit, four conditional skips and a halt. Any other word is passed through unchanged. A class word whose select field is empty or has several bits set raises the illegal indication and changes no state.

Top module: `rrx_exec`

## Requirements
- R1: A strobed word whose bits [15:12] differ from 4'h7 leaves AC, E and PC equal to the strobed inputs and keeps `illegal` at 0.
- R2: Select bit 11 clears AC, bit 10 clears E, bit 9 inverts every AC bit and bit 8 inverts E. The other state passes unchanged.
- R3: Select bit 5 adds one to AC modulo 2^16 and leaves E unchanged.
- R4: Select bit 7 rotates {AC,E} right, so the old E enters AC[15] and AC[0] becomes E. Select bit 6 rotates left, so the old E enters AC[0] and AC[15] becomes E.
- R5: Select bits 4, 3, 2 and 1 skip when AC[15]=0, AC[15]=1, AC=0 and E=0 respectively. A skip gives PC = pc_in+1, and in every other executed case PC = pc_in.
- R6: A class word with zero or two or more select bits set drives `illegal` to 1 and passes AC, E and PC through unchanged. It never sets `halt`, even when bit 0 is among the set bits.
- R7: Select bit 0 sets `halt`. The flag stays set until reset, and while it is set strobed words change no output.
- R8: While the strobe is low, all outputs hold their values.
- R9: After reset, AC, E, PC, `halt` and `illegal` are all 0.
- R10: The results of a word strobed at a rising clock edge appear at the outputs right after that edge and stay there until the next accepted strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| exec | input | 1 | Execute strobe for the current word |
| instr | input | 16 | Instruction word |
| ac_in | input | 16 | Current accumulator |
| e_in | input | 1 | Current extend bit |
| pc_in | input | 12 | Current program counter, already past the instruction |
| ac_out | output | 16 | Next accumulator |
| e_out | output | 1 | Next extend bit |
| pc_out | output | 12 | Next program counter |
| halt | output | 1 | Sticky halt flag |
| illegal | output | 1 | Last accepted word was a malformed class word |

## Verification
The halt operation can collide with another operation, because a malformed word may set bit 0 together with any other select bit. The sweep applies every pair of select bits, including each pair that contains the halt bit. Each such word must raise `illegal`, keep `halt` low and pass the state through untouched. A single-bit halt is applied last. After it, a further strobed word must leave every output frozen.

// File: rtl/rrx_pkg.sv
package rrx_pkg;
   localparam int INSTR_W   = 16;
   localparam int SEL_W     = 12;
   localparam logic [3:0] CLASS_TAG = 4'h7;

   // positions inside the select field; behaviour depends on these
   localparam int B_CLA = 11;
   localparam int B_CLE = 10;
   localparam int B_CMA = 9;
   localparam int B_CME = 8;
   localparam int B_CIR = 7;
   localparam int B_CIL = 6;
   localparam int B_INC = 5;
   localparam int B_SPA = 4;
   localparam int B_SNA = 3;
   localparam int B_SZA = 2;
   localparam int B_SZE = 1;
   localparam int B_HLT = 0;

   localparam int NUM_SKIP  = 4;
   localparam int SKIP_LO   = B_SZE;
endpackage

// File: rtl/rrx_decode.sv
module rrx_decode
   import rrx_pkg::*;
(
   input  logic [INSTR_W-1:0] word,
   output logic               in_class,
   output logic               legal,
   output logic [SEL_W-1:0]   sel
);
   logic single;

   always_comb begin
      in_class = (word[INSTR_W-1 -: 4] == CLASS_TAG);
      sel      = word[SEL_W-1:0];
      single   = (sel != '0) && ((sel & (sel - 1'b1)) == '0);
      legal    = in_class && single;
   end
endmodule

// File: rtl/rrx_alu.sv
module rrx_alu
   import rrx_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic [SEL_W-1:0]  sel,
   input  logic [DATA_W-1:0] ac,
   input  logic              e,
   output logic [DATA_W-1:0] ac_nxt,
   output logic              e_nxt,
   output logic              skip
);
   localparam int MSB = DATA_W - 1;

   logic [NUM_SKIP-1:0] cond;
   logic [NUM_SKIP-1:0] hit;

   always_comb begin
      cond[B_SZE - SKIP_LO] = ~e;
      cond[B_SZA - SKIP_LO] = (ac == '0);
      cond[B_SNA - SKIP_LO] = ac[MSB];
      cond[B_SPA - SKIP_LO] = ~ac[MSB];
   end

   for (genvar k = 0; k < NUM_SKIP; k++) begin : g_skip
      assign hit[k] = cond[k] & sel[SKIP_LO + k];
   end

   assign skip = |hit;

   always_comb begin
      ac_nxt = ac;
      e_nxt  = e;
      if (sel[B_CLA]) ac_nxt = '0;
      if (sel[B_CLE]) e_nxt  = 1'b0;
      if (sel[B_CMA]) ac_nxt = ~ac;
      if (sel[B_CME]) e_nxt  = ~e;
      if (sel[B_INC]) ac_nxt = ac + 1'b1;
      if (sel[B_CIR]) begin
         ac_nxt = {e, ac[MSB:1]};
         e_nxt  = ac[0];
      end
      if (sel[B_CIL]) begin
         ac_nxt = {ac[MSB-1:0], e};
         e_nxt  = ac[MSB];
      end
   end
endmodule

// File: rtl/rrx_exec.sv
module rrx_exec
   import rrx_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int PC_W   = 12
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 exec,
   input  logic [INSTR_W-1:0]   instr,
   input  logic [DATA_W-1:0]    ac_in,
   input  logic                 e_in,
   input  logic [PC_W-1:0]      pc_in,
   output logic [DATA_W-1:0]    ac_out,
   output logic                 e_out,
   output logic [PC_W-1:0]      pc_out,
   output logic                 halt,
   output logic                 illegal
);
   logic              in_class, legal;
   logic [SEL_W-1:0]  sel;
   logic [DATA_W-1:0] ac_nxt;
   logic              e_nxt, skip;
   logic              take;

   logic [DATA_W-1:0] ac_q;
   logic              e_q, halt_q, ill_q;
   logic [PC_W-1:0]   pc_q;

   rrx_decode u_dec (
      .word     (instr),
      .in_class (in_class),
      .legal    (legal),
      .sel      (sel)
   );

   rrx_alu #(.DATA_W(DATA_W)) u_alu (
      .sel    (sel),
      .ac     (ac_in),
      .e      (e_in),
      .ac_nxt (ac_nxt),
      .e_nxt  (e_nxt),
      .skip   (skip)
   );

   assign take = exec && !halt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ac_q   <= '0;
         e_q    <= 1'b0;
         pc_q   <= '0;
         halt_q <= 1'b0;
         ill_q  <= 1'b0;
      end else if (take) begin
         ill_q <= in_class && !legal;
         if (legal) begin
            ac_q   <= ac_nxt;
            e_q    <= e_nxt;
            pc_q   <= pc_in + PC_W'(skip);
            halt_q <= sel[B_HLT];
         end else begin
            ac_q <= ac_in;
            e_q  <= e_in;
            pc_q <= pc_in;
         end
      end
   end

   assign ac_out  = ac_q;
   assign e_out   = e_q;
   assign pc_out  = pc_q;
   assign halt    = halt_q;
   assign illegal = ill_q;

   // R6: a malformed class word leaves the state as it was given
   a_r6_illegal_passes: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(illegal) |-> (ac_out == $past(ac_in)) && (e_out == $past(e_in))
                         && (pc_out == $past(pc_in)) && !halt);

   // R7: halt is sticky and freezes the outputs
   a_r7_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      halt |=> halt && $stable(ac_out) && $stable(pc_out) && $stable(e_out));

   // R8: no strobe, no change
   a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !exec |=> $stable(ac_out) && $stable(e_out) && $stable(pc_out) && $stable(illegal));

   // R5: program counter advances by at most one extra step
   a_r5_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> (pc_out == $past(pc_in)) || (pc_out == PC_W'($past(pc_in) + 1'b1)));

   // R4: right rotation hands the low accumulator bit to E
   a_r4_cir_e: assert property (@(posedge clk) disable iff (!rst_n)
      (take && legal && sel[B_CIR]) |=> (e_out == $past(ac_in[0]))
                                        && (ac_out[DATA_W-1] == $past(e_in)));
endmodule

// File: tb/test_rrx_exec.sv
`timescale 1ns/1ps
module test_rrx_exec;
   localparam int DW = 16;
   localparam int PW = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          exec = 1'b0;
   logic [15:0]   instr = '0;
   logic [DW-1:0] ac_in = '0;
   logic          e_in = 1'b0;
   logic [PW-1:0] pc_in = '0;
   logic [DW-1:0] ac_out;
   logic          e_out;
   logic [PW-1:0] pc_out;
   logic          halt, illegal;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   rrx_exec #(.DATA_W(DW), .PC_W(PW)) i_rrx_exec (
      .clk(clk), .rst_n(rst_n), .exec(exec), .instr(instr),
      .ac_in(ac_in), .e_in(e_in), .pc_in(pc_in),
      .ac_out(ac_out), .e_out(e_out), .pc_out(pc_out),
      .halt(halt), .illegal(illegal)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // reference model built from the requirements
   task automatic model(input logic [15:0] w, input logic [DW-1:0] a, input logic e,
                        input logic [PW-1:0] p,
                        output logic [DW-1:0] xa, output logic xe,
                        output logic [PW-1:0] xp, output logic xi, output logic xh);
      logic [11:0] s;
      int cnt;
      s = w[11:0];
      cnt = $countones(s);
      xa = a; xe = e; xp = p; xi = 1'b0; xh = 1'b0;
      if (w[15:12] != 4'h7) return;
      if (cnt != 1) begin xi = 1'b1; return; end
      case (1'b1)
         s[11]: xa = '0;
         s[10]: xe = 1'b0;
         s[9]:  xa = ~a;
         s[8]:  xe = ~e;
         s[7]:  begin xa = (a >> 1) | (DW'(e) << (DW-1)); xe = a[0]; end
         s[6]:  begin xa = (a << 1) | DW'(e); xe = a[DW-1]; end
         s[5]:  xa = DW'(a + 1);
         s[4]:  if (a[DW-1] == 1'b0) xp = PW'(p + 1);
         s[3]:  if (a[DW-1] == 1'b1) xp = PW'(p + 1);
         s[2]:  if (a == '0) xp = PW'(p + 1);
         s[1]:  if (e == 1'b0) xp = PW'(p + 1);
         s[0]:  xh = 1'b1;
         default: ;
      endcase
   endtask

   task automatic apply(input logic [15:0] w, input logic [DW-1:0] a, input logic e,
                        input logic [PW-1:0] p, input string tag);
      logic [DW-1:0] xa; logic xe; logic [PW-1:0] xp; logic xi, xh;
      model(w, a, e, p, xa, xe, xp, xi, xh);
      @(negedge clk);
      instr = w; ac_in = a; e_in = e; pc_in = p; exec = 1'b1;
      @(posedge clk);
      @(negedge clk);
      exec = 1'b0;
      chk({tag, " ac"}, 32'(ac_out), 32'(xa));
      chk({tag, " e"},  32'(e_out),  32'(xe));
      chk({tag, " pc"}, 32'(pc_out), 32'(xp));
      chk({tag, " illegal"}, 32'(illegal), 32'(xi));
      chk({tag, " halt"}, 32'(halt), 32'(xh));
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] pats [8];
      logic [DW-1:0] la;
      logic [PW-1:0] lp;
      logic le;
      pats[0] = 16'h0000; pats[1] = 16'h0001; pats[2] = 16'h7FFF; pats[3] = 16'h8000;
      pats[4] = 16'hFFFF; pats[5] = 16'h1234; pats[6] = 16'hA5A5; pats[7] = 16'h4000;

      repeat (3) @(negedge clk);
      // R9 reset state
      chk("R9 ac", 32'(ac_out), 0);
      chk("R9 e", 32'(e_out), 0);
      chk("R9 pc", 32'(pc_out), 0);
      chk("R9 halt", 32'(halt), 0);
      chk("R9 illegal", 32'(illegal), 0);
      rst_n = 1'b1;

      // R2 R3 R4 R5 R10: every non-halt operation over patterns and E values
      for (int b = 1; b < 12; b++) begin
         for (int i = 0; i < 8; i++) begin
            for (int e = 0; e < 2; e++) begin
               apply(16'h7000 | (16'h1 << b), pats[i], e[0], PW'(12'h0FF + i * 301 + b),
                     $sformatf("R2/R3/R4/R5/R10 bit%0d", b));
            end
         end
      end
      // R5 wrap of the program counter on a skip
      apply(16'h7004, 16'h0000, 1'b0, 12'hFFF, "R5 pc wrap");

      // R6 empty field and every two-bit combination, halt bit included
      apply(16'h7000, 16'h5555, 1'b1, 12'h123, "R6 empty");
      for (int i = 0; i < 12; i++) begin
         for (int j = i + 1; j < 12; j++) begin
            apply(16'h7000 | (16'h1 << i) | (16'h1 << j), pats[(i + j) % 8], j[0],
                  PW'(i * 100 + j), "R6 pair");
         end
      end
      apply(16'h7FFF, 16'h8001, 1'b0, 12'h777, "R6 all bits");

      // R1 words outside the class
      apply(16'hF800, 16'h00F0, 1'b1, 12'h010, "R1 io word");
      apply(16'h0801, 16'hFFFF, 1'b0, 12'h020, "R1 mem word");
      apply(16'h6001, 16'h0000, 1'b1, 12'hFFF, "R1 mem word2");
      apply(16'hF001, 16'h1111, 1'b0, 12'h030, "R1 high class");

      // R8 strobe low: inputs change, outputs hold
      apply(16'h7020, 16'h00FE, 1'b1, 12'h040, "R8 setup");
      @(negedge clk);
      instr = 16'h7800; ac_in = 16'hBEEF; e_in = 1'b0; pc_in = 12'h555; exec = 1'b0;
      repeat (3) @(negedge clk);
      chk("R8 ac hold", 32'(ac_out), 32'h00FF);
      chk("R8 e hold", 32'(e_out), 1);
      chk("R8 pc hold", 32'(pc_out), 32'h040);

      // R7 halt, then a later word is ignored
      apply(16'h7001, 16'h2468, 1'b1, 12'h0AA, "R7 halt");
      la = ac_out; le = e_out; lp = pc_out;
      @(negedge clk);
      instr = 16'h7200; ac_in = 16'h0F0F; e_in = 1'b0; pc_in = 12'h0BB; exec = 1'b1;
      @(posedge clk); @(negedge clk);
      exec = 1'b0;
      chk("R7 frozen ac", 32'(ac_out), 32'(la));
      chk("R7 frozen e", 32'(e_out), 32'(le));
      chk("R7 frozen pc", 32'(pc_out), 32'(lp));
      chk("R7 halt kept", 32'(halt), 1);

      // R9 reset clears the halt
      rst_n = 1'b0;
      @(negedge clk);
      chk("R9 halt cleared", 32'(halt), 0);
      rst_n = 1'b1;
      apply(16'h7080, 16'h0001, 1'b0, 12'h001, "R4 after reset");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule